// File: doc/BRIEF.md
# Dynamic Voltage Code Slew Controller

This block drives the 6-bit output-voltage code of one switching converter. Two target codes arrive from a register file, a low target and a high target, and a select pin picks which one applies. When the selected target differs from the applied code, the block walks the applied code toward the target by one LSB per step. The time between steps is counted in microsecond ticks. It depends on the programmed slew setting and on the voltage size of the step. One slew setting skips the ramp and applies the target at once.

The code maps to voltage in three regions. Codes 0 to 31 give 0.800 V plus 25 mV per LSB. Codes 32 to 60 give 1.600 V plus 50 mV per LSB. Codes 61, 62 and 63 give 3.1, 3.2 and 3.3 V. A step therefore spans 25 mV, 50 mV or 100 mV. The dwell for each step is the step voltage divided by the slew rate, rounded to whole microseconds. A busy output stays high while the applied code differs from the selected target. It is a pure code compare and does not wait for the analog output to settle.

The register file outside this block holds the reset defaults: low target 16 (1.2 V), high target 8 (1.0 V) and slew setting 6. The applied code itself resets to the parameter `INIT_CODE`, which defaults to 16.

Top module: `dvs_code_slew`

## Requirements
- R1: The selected target is `high_code_i` when `sel_i` is 1 and `low_code_i` when `sel_i` is 0. A select-pin edge starts a new transition in the same way a register change does.
- R2: Each ramp step changes `code_o` by exactly one LSB toward the target. The code never passes the target and stops on it.
- R3: A step whose upper code is 32 or below (25 mV) waits 227, 114, 56, 28, 14, 7 or 3 ticks for slew values 0 to 6, where the rates are 0.11, 0.22, 0.45, 0.9, 1.8, 3.6 and 7.2 mV/us.
- R4: A step whose upper code is 33 to 60 (50 mV) waits 455, 227, 111, 56, 28, 14 or 7 ticks for slew values 0 to 6.
- R5: A step whose upper code is 61 to 63 (100 mV) waits 909, 455, 222, 111, 56, 28 or 14 ticks for slew values 0 to 6.
- R6: With slew value 7, `code_o` equals the selected target after the next clock edge.
- R7: `busy_o` is 1 exactly when `code_o` differs from the selected target, and 0 as soon as they match.
- R8: A target change during a ramp restarts the dwell count and continues from the present `code_o`, with no jump.
- R9: Only cycles with `us_tick_i` high advance the dwell count. With no ticks, `code_o` holds.
- R10: After reset `code_o` is `INIT_CODE` (16), and the dwell count is restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| low_code_i | input | 6 | Target code used when select is low |
| high_code_i | input | 6 | Target code used when select is high |
| sel_i | input | 1 | Target select pin |
| slew_i | input | 3 | Slew setting; 7 applies the target at once |
| code_o | output | 6 | Applied voltage code |
| busy_o | output | 1 | Transition in progress |

## Verification
A wrong dwell count or step class shows up at `code_o` as a step arriving one or more ticks early or late. This is visible within a single step interval, at most 909 ticks. A wrong direction or a missed stop shows as a code that leaves the start–target range, or as `busy_o` staying high, on the very next step. A stale target register shows as a missing restart after a select edge, which is visible within one dwell interval.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  localparam int CODE_W   = 6;
  localparam int SLEW_W   = 3;
  localparam int CNT_W    = 10;
  localparam int FINE_TOP = 32;  // highest upper code of a 25 mV step
  localparam int MID_TOP  = 60;  // highest upper code of a 50 mV step
  localparam logic [SLEW_W-1:0] SLEW_IMM = 3'd7;

  typedef enum logic [1:0] {STEP_FINE, STEP_MID, STEP_COARSE} step_cls_e;

  function automatic step_cls_e step_class(input logic [CODE_W-1:0] upper);
    if (int'(upper) <= FINE_TOP) return STEP_FINE;
    else if (int'(upper) <= MID_TOP) return STEP_MID;
    else return STEP_COARSE;
  endfunction

  // ticks per step = step mV / rate, rounded
  function automatic logic [CNT_W-1:0] dwell_ticks(input step_cls_e cls,
                                                    input logic [SLEW_W-1:0] slew);
    logic [CNT_W-1:0] d;
    d = 10'd3;
    case (cls)
      STEP_FINE: case (slew)
        3'd0: d = 10'd227; 3'd1: d = 10'd114; 3'd2: d = 10'd56;
        3'd3: d = 10'd28;  3'd4: d = 10'd14;  3'd5: d = 10'd7;
        default: d = 10'd3;
      endcase
      STEP_MID: case (slew)
        3'd0: d = 10'd455; 3'd1: d = 10'd227; 3'd2: d = 10'd111;
        3'd3: d = 10'd56;  3'd4: d = 10'd28;  3'd5: d = 10'd14;
        default: d = 10'd7;
      endcase
      default: case (slew)
        3'd0: d = 10'd909; 3'd1: d = 10'd455; 3'd2: d = 10'd222;
        3'd3: d = 10'd111; 3'd4: d = 10'd56;  3'd5: d = 10'd28;
        default: d = 10'd14;
      endcase
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dvs_target_sel.sv
module dvs_target_sel
  import dvs_pkg::*;
#(
  parameter int W = CODE_W,
  parameter logic [W-1:0] INIT_CODE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] low_i,
  input  logic [W-1:0] high_i,
  input  logic         sel_i,
  output logic [W-1:0] target_o,
  output logic         chg_o
);
  logic [W-1:0] target_q;

  assign target_o = sel_i ? high_i : low_i;
  assign chg_o    = (target_o != target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) target_q <= INIT_CODE;
    else         target_q <= target_o;
  end
endmodule

// File: rtl/dvs_dwell_timer.sv
module dvs_dwell_timer
  import dvs_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [CW-1:0] dwell_i,
  output logic          step_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == dwell_i - CW'(1));
  assign step_o = !restart_i && tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || step_o) cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/dvs_code_stepper.sv
module dvs_code_stepper
  import dvs_pkg::*;
#(
  parameter int W = CODE_W,
  parameter logic [W-1:0] INIT_CODE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] target_i,
  input  logic         jump_i,
  input  logic         step_i,
  output logic [W-1:0] code_o,
  output logic         moving_o,
  output step_cls_e    cls_o
);
  logic [W-1:0] code_q;
  logic         up;
  logic [W-1:0] upper;

  assign up       = (target_i > code_q);
  assign moving_o = (target_i != code_q);
  // step size is set by the higher code of the pair
  assign upper    = up ? code_q + W'(1) : code_q;
  assign cls_o    = step_class(upper);
  assign code_o   = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= INIT_CODE;
    else if (jump_i) code_q <= target_i;
    else if (step_i && moving_o)
      code_q <= up ? code_q + W'(1) : code_q - W'(1);
  end
endmodule

// File: rtl/dvs_code_slew.sv
module dvs_code_slew
  import dvs_pkg::*;
#(
  parameter logic [CODE_W-1:0] INIT_CODE = 6'd16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              us_tick_i,
  input  logic [CODE_W-1:0] low_code_i,
  input  logic [CODE_W-1:0] high_code_i,
  input  logic              sel_i,
  input  logic [SLEW_W-1:0] slew_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] target;
  logic              tgt_chg;
  logic              jump;
  logic              moving;
  logic              step;
  step_cls_e         cls;
  logic [CNT_W-1:0]  dwell;

  assign jump  = (slew_i == SLEW_IMM);
  assign dwell = dwell_ticks(cls, slew_i);

  dvs_target_sel #(.W(CODE_W), .INIT_CODE(INIT_CODE)) u_sel (
    .clk_i, .rst_ni,
    .low_i(low_code_i), .high_i(high_code_i), .sel_i,
    .target_o(target), .chg_o(tgt_chg)
  );

  dvs_dwell_timer #(.CW(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .tick_i(us_tick_i),
    .restart_i(tgt_chg || jump || !moving),
    .dwell_i(dwell),
    .step_o(step)
  );

  dvs_code_stepper #(.W(CODE_W), .INIT_CODE(INIT_CODE)) u_step (
    .clk_i, .rst_ni,
    .target_i(target), .jump_i(jump), .step_i(step),
    .code_o, .moving_o(moving), .cls_o(cls)
  );

  assign busy_o = moving;
endmodule

// File: rtl/dvs_code_slew_chk.sv
module dvs_code_slew_chk
  import dvs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              us_tick_i,
  input logic [CODE_W-1:0] low_code_i,
  input logic [CODE_W-1:0] high_code_i,
  input logic              sel_i,
  input logic [SLEW_W-1:0] slew_i,
  input logic [CODE_W-1:0] code_o,
  input logic              busy_o
);
  logic [CODE_W-1:0] tgt;
  assign tgt = sel_i ? high_code_i : low_code_i;

  p_one_lsb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew_i != SLEW_IMM) |=> ((code_o == $past(code_o)) ||
      (code_o == $past(code_o) + 6'd1) || (code_o == $past(code_o) - 6'd1)));

  p_toward_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew_i != SLEW_IMM && code_o < tgt) |=> (code_o >= $past(code_o)));

  p_toward_dn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew_i != SLEW_IMM && code_o > tgt) |=> (code_o <= $past(code_o)));

  p_immediate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew_i == SLEW_IMM) |=> (code_o == $past(tgt)));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |=> ($stable(code_o) || $past(tgt) != $past(code_o)));

  p_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!us_tick_i && slew_i != SLEW_IMM) |=> $stable(code_o));
endmodule

bind dvs_code_slew dvs_code_slew_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .us_tick_i(us_tick_i),
  .low_code_i(low_code_i), .high_code_i(high_code_i), .sel_i(sel_i),
  .slew_i(slew_i), .code_o(code_o), .busy_o(busy_o)
);

// File: tb/tb_dvs_code_slew.sv
`timescale 1ns/1ps
module tb_dvs_code_slew;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       us_tick_i = 1'b1;
  logic [5:0] low_code_i = 6'd16;
  logic [5:0] high_code_i = 6'd8;
  logic       sel_i = 1'b0;
  logic [2:0] slew_i = 3'd6;
  logic [5:0] code_o;
  logic       busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dvs_code_slew dut (.*);

  // {slew, start, dest}
  localparam logic [14:0] VEC [0:9] = '{
    {3'd0, 6'd5,  6'd6},
    {3'd3, 6'd20, 6'd18},
    {3'd4, 6'd31, 6'd32},
    {3'd4, 6'd33, 6'd32},
    {3'd5, 6'd45, 6'd50},
    {3'd1, 6'd59, 6'd60},
    {3'd6, 6'd60, 6'd61},
    {3'd2, 6'd63, 6'd62},
    {3'd6, 6'd10, 6'd9},
    {3'd0, 6'd61, 6'd62}
  };

  function automatic real volts(int c);
    if (c < 32)      return 0.8 + 0.025 * c;
    else if (c < 61) return 1.6 + 0.05 * (c - 32);
    else             return 3.1 + 0.1 * (c - 61);
  endfunction

  function automatic real rate(int s);
    case (s)
      0: return 0.11; 1: return 0.22; 2: return 0.45; 3: return 0.9;
      4: return 1.8;  5: return 3.6;  default: return 7.2;
    endcase
  endfunction

  function automatic int exp_dwell(int s, int from, int to);
    int  nxt;
    real dv;
    nxt = (to > from) ? from + 1 : from - 1;
    dv = (volts(nxt) - volts(from)) * 1000.0;
    if (dv < 0.0) dv = -dv;
    return $rtoi(dv / rate(s) + 0.5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nedge(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    nedge(3);
    rst_ni = 1'b1;
    #1;
    chk(code_o == 6'd16, "R10 reset code", code_o, 16);
    chk(busy_o == 1'b0, "R10 reset busy", busy_o, 0);

    // select high with immediate slew
    @(negedge clk_i);
    slew_i = 3'd7; sel_i = 1'b1;
    #1;
    chk(busy_o == 1'b1, "R7 busy on target change", busy_o, 1);
    nedge(1);
    chk(code_o == 6'd8, "R1/R6 high target applied", code_o, 8);
    chk(busy_o == 1'b0, "R7 busy clears", busy_o, 0);
    sel_i = 1'b0;
    nedge(1);
    chk(code_o == 6'd16, "R1 low target applied", code_o, 16);

    for (int v = 0; v < 10; v++) begin
      int s, st, ds, n, nx, hi, lim;
      bit out_rng;
      string tag;
      s  = int'(VEC[v][14:12]);
      st = int'(VEC[v][11:6]);
      ds = int'(VEC[v][5:0]);
      n  = exp_dwell(s, st, ds);
      nx = (ds > st) ? st + 1 : st - 1;
      hi = (nx > st) ? nx : st;
      tag = (hi <= 32) ? "R3" : (hi <= 60) ? "R4" : "R5";
      slew_i = 3'd7; sel_i = 1'b0; low_code_i = 6'(st);
      nedge(2);
      high_code_i = 6'(ds); slew_i = 3'(s); sel_i = 1'b1;
      nedge(n);
      chk(code_o == 6'(st) && busy_o, {tag, " no early step"}, code_o, st);
      nedge(1);
      chk(code_o == 6'(nx), {tag, " step at dwell"}, code_o, nx);
      lim = 0; out_rng = 0;
      while ((busy_o || code_o != 6'(ds)) && lim < 5000) begin
        nedge(1);
        lim++;
        if ((ds > st && (code_o > 6'(ds) || code_o < 6'(st))) ||
            (ds < st && (code_o < 6'(ds) || code_o > 6'(st)))) out_rng = 1;
      end
      chk(code_o == 6'(ds) && !busy_o && !out_rng, "R2 reaches target", code_o, ds);
    end

    // R9: no ticks, no motion
    slew_i = 3'd7; sel_i = 1'b0; low_code_i = 6'd16;
    nedge(2);
    us_tick_i = 1'b0; high_code_i = 6'd20; slew_i = 3'd6; sel_i = 1'b1;
    nedge(50);
    chk(code_o == 6'd16, "R9 holds without ticks", code_o, 16);
    chk(busy_o == 1'b1, "R7 busy while pending", busy_o, 1);
    us_tick_i = 1'b1;
    nedge(2);
    chk(code_o == 6'd16, "R9 two ticks not enough", code_o, 16);
    nedge(1);
    chk(code_o == 6'd17, "R9 step on third tick", code_o, 17);

    // R8: reversal mid-ramp
    sel_i = 1'b0;
    nedge(3);
    chk(code_o == 6'd17, "R8 no jump on reversal", code_o, 17);
    nedge(1);
    chk(code_o == 6'd16, "R8 step back after restart", code_o, 16);
    nedge(20);
    chk(code_o == 6'd16 && !busy_o, "R2 no overshoot", code_o, 16);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule